// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a virtual address into a physical address through a small, fully associative store of page mappings. The low bits of the address are the in-page offset. Their count is the base-two logarithm of the page size, which is 12 bits for the default 4 KiB page. The remaining high bits form the virtual page number. Every entry compares its page number against the request at the same time. A matching valid entry supplies its frame number, and the frame number is joined with the untouched offset. The result appears in the same cycle as the request.

Each entry holds a valid flag, a page number, a frame number, separate read-allow and write-allow flags, and two usage flags. The referenced flag marks any successful use, and the modified flag marks a successful store. The hardware sets these flags on every allowed access. A request that finds no valid entry raises a page fault. A request that finds an entry whose flags forbid the operation raises a protection fault. Both faults are left for software to handle.

Software fills or invalidates one entry at a time through a load port. Loading an entry always clears its usage flags. A single strobe clears every referenced flag, so software can track which pages were used recently. A status port reads back the usage flags of one chosen entry.

Top module: `page_xlate_unit`

## Requirements
- R1: The offset is the low log2(PAGE_BYTES) bits of the address (12 by default). The page number is the bits above it. A hit outputs {frame number, offset}, with the offset unchanged, including offsets 0x000 and 0xFFF and page number 0xFFFFF.
- R2: A valid request whose page number matches a valid entry, and whose operation that entry allows, gives rsp_hit_o=1 and the translated address in the same cycle.
- R3: A valid request that matches no valid entry gives rsp_page_fault_o=1, rsp_hit_o=0 and rsp_paddr_o=0.
- R4: A read needs the entry's read-allow flag and a store needs its write-allow flag. Otherwise rsp_prot_fault_o=1, rsp_hit_o=0 and rsp_paddr_o=0.
- R5: At most one of rsp_hit_o, rsp_page_fault_o and rsp_prot_fault_o is high in any cycle. All three, and rsp_paddr_o, are 0 while req_valid_i is low.
- R6: A successful access sets the entry's referenced flag from the next cycle on. A faulting access changes no usage flag.
- R7: A successful store also sets the modified flag. A successful read leaves the modified flag unchanged.
- R8: A load sets the entry's contents from the next cycle on and clears its referenced and modified flags. Loading with ld_valid_i=0 invalidates the entry, so its page faults.
- R9: clr_ref_i clears every referenced flag and keeps the modified flags. An entry that is successfully accessed in the same cycle stays referenced.
- R10: When several valid entries match, the entry with the lowest index supplies the translation and receives the flag updates.
- R11: When a load and an access target the same entry in one cycle, the response uses the old contents and the load wins the state update.
- R12: After reset, every entry is invalid, every usage flag is 0 and every request page faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_vaddr_i | input | VA_W | Virtual address |
| req_store_i | input | 1 | 1 = store, 0 = read |
| rsp_hit_o | output | 1 | Translation succeeded |
| rsp_paddr_o | output | PA_W | Physical address, 0 when not a hit |
| rsp_page_fault_o | output | 1 | No valid entry for the page |
| rsp_prot_fault_o | output | 1 | Operation not allowed on the page |
| ld_en_i | input | 1 | Load strobe for one entry |
| ld_idx_i | input | IDX_W | Entry to load |
| ld_valid_i | input | 1 | Valid flag to load |
| ld_vpn_i | input | VPN_W | Page number to load |
| ld_pfn_i | input | PFN_W | Frame number to load |
| ld_rd_ok_i | input | 1 | Read-allow flag to load |
| ld_wr_ok_i | input | 1 | Write-allow flag to load |
| clr_ref_i | input | 1 | Clear all referenced flags |
| stat_idx_i | input | IDX_W | Entry whose usage flags are read back |
| stat_ref_o | output | 1 | Referenced flag of the selected entry |
| stat_mod_o | output | 1 | Modified flag of the selected entry |

## Verification
The bench covers several cycle-boundary corner cases. It stores to a read-only page, reads from a write-only page, and checks that neither attempt sets a usage flag. A design that updates the flags before checking permission would mark such pages as referenced or modified. It loads an entry in the same cycle as an access to it, which exposes a design that answers from the new contents or lets the access flag survive the load. It issues the clear strobe together with an access, which catches a wrong priority between clearing and setting. It also places duplicate mappings in two slots, which catches a selector that picks the wrong slot or updates both. Offsets at both ends of the page and the all-ones page number catch slicing errors in the split.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } perm_t;

  typedef enum logic [1:0] {
    RES_NONE,
    RES_HIT,
    RES_PFAULT,
    RES_PROT
  } xlate_res_e;
endpackage

// File: rtl/xlate_entry.sv
module xlate_entry #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                ld_valid_i,
  input  logic [VPN_W-1:0]    ld_vpn_i,
  input  logic [PFN_W-1:0]    ld_pfn_i,
  input  xlate_pkg::perm_t    ld_perm_i,
  input  logic                clr_ref_i,
  input  logic                use_i,
  input  logic                use_store_i,
  input  logic [VPN_W-1:0]    lookup_vpn_i,
  output logic                match_o,
  output logic [PFN_W-1:0]    pfn_o,
  output xlate_pkg::perm_t    perm_o,
  output logic                ref_o,
  output logic                mod_o
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] pfn_q;
  xlate_pkg::perm_t perm_q;
  logic             ref_q;
  logic             mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      pfn_q   <= '0;
      perm_q  <= '0;
      ref_q   <= 1'b0;
      mod_q   <= 1'b0;
    end else if (ld_i) begin
      // load wins over same-cycle use and clear
      valid_q <= ld_valid_i;
      vpn_q   <= ld_vpn_i;
      pfn_q   <= ld_pfn_i;
      perm_q  <= ld_perm_i;
      ref_q   <= 1'b0;
      mod_q   <= 1'b0;
    end else begin
      if (use_i)          ref_q <= 1'b1;
      else if (clr_ref_i) ref_q <= 1'b0;
      if (use_i && use_store_i) mod_q <= 1'b1;
    end
  end

  assign match_o = valid_q && (vpn_q == lookup_vpn_i);
  assign pfn_o   = pfn_q;
  assign perm_o  = perm_q;
  assign ref_o   = ref_q;
  assign mod_o   = mod_q;

  // R8
  load_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (!ref_q && !mod_q));
  // R6
  use_sets_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !ld_i) |=> ref_q);
  // R9
  clr_ref_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ref_i && !use_i && !ld_i) |=> !ref_q);
  // R7
  mod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !(use_i && use_store_i)) |=> (mod_q == $past(mod_q)));
endmodule

// File: rtl/xlate_select.sv
module xlate_select #(
  parameter int N     = 8,
  parameter int PFN_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]                  match_i,
  input  logic [N-1:0][PFN_W-1:0]       pfn_i,
  input  xlate_pkg::perm_t [N-1:0]      perm_i,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o,
  output logic [PFN_W-1:0]              pfn_o,
  output xlate_pkg::perm_t              perm_o
);
  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    pfn_o  = '0;
    perm_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        any_o  = 1'b1;
        idx_o  = IDX_W'(i);
        pfn_o  = pfn_i[i];
        perm_o = perm_i[i];
      end
    end
  end
endmodule

// File: rtl/xlate_check.sv
module xlate_check (
  input  logic                  req_valid_i,
  input  logic                  req_store_i,
  input  logic                  any_i,
  input  xlate_pkg::perm_t      perm_i,
  output xlate_pkg::xlate_res_e res_o
);
  import xlate_pkg::*;
  always_comb begin
    res_o = RES_NONE;
    if (req_valid_i) begin
      if (!any_i)                                 res_o = RES_PFAULT;
      else if (req_store_i ? perm_i.wr : perm_i.rd) res_o = RES_HIT;
      else                                        res_o = RES_PROT;
    end
  end
endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int N          = 8,
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int PFN_W = PA_W - OFF_W,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_store_i,
  output logic             rsp_hit_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic             ld_valid_i,
  input  logic [VPN_W-1:0] ld_vpn_i,
  input  logic [PFN_W-1:0] ld_pfn_i,
  input  logic             ld_rd_ok_i,
  input  logic             ld_wr_ok_i,
  input  logic             clr_ref_i,
  input  logic [IDX_W-1:0] stat_idx_i,
  output logic             stat_ref_o,
  output logic             stat_mod_o
);
  import xlate_pkg::*;

  logic [VPN_W-1:0]          req_vpn;
  logic [OFF_W-1:0]          req_off;
  logic [N-1:0]              match_v;
  logic [N-1:0]              use_v;
  logic [N-1:0]              ref_v;
  logic [N-1:0]              mod_v;
  logic [N-1:0][PFN_W-1:0]   pfn_a;
  perm_t [N-1:0]             perm_a;
  perm_t                     ld_perm;
  logic                      any_hit;
  logic [IDX_W-1:0]          sel_idx;
  logic [PFN_W-1:0]          sel_pfn;
  perm_t                     sel_perm;
  xlate_res_e                res;

  assign req_vpn = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off = req_vaddr_i[OFF_W-1:0];
  assign ld_perm = '{rd: ld_rd_ok_i, wr: ld_wr_ok_i};

  for (genvar g = 0; g < N; g++) begin : g_ent
    assign use_v[g] = (res == RES_HIT) && (sel_idx == IDX_W'(g));
    xlate_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) ent_i (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .ld_i         (ld_en_i && (ld_idx_i == IDX_W'(g))),
      .ld_valid_i   (ld_valid_i),
      .ld_vpn_i     (ld_vpn_i),
      .ld_pfn_i     (ld_pfn_i),
      .ld_perm_i    (ld_perm),
      .clr_ref_i    (clr_ref_i),
      .use_i        (use_v[g]),
      .use_store_i  (req_store_i),
      .lookup_vpn_i (req_vpn),
      .match_o      (match_v[g]),
      .pfn_o        (pfn_a[g]),
      .perm_o       (perm_a[g]),
      .ref_o        (ref_v[g]),
      .mod_o        (mod_v[g])
    );
  end

  xlate_select #(.N(N), .PFN_W(PFN_W)) sel_i (
    .match_i (match_v),
    .pfn_i   (pfn_a),
    .perm_i  (perm_a),
    .any_o   (any_hit),
    .idx_o   (sel_idx),
    .pfn_o   (sel_pfn),
    .perm_o  (sel_perm)
  );

  xlate_check chk_i (
    .req_valid_i (req_valid_i),
    .req_store_i (req_store_i),
    .any_i       (any_hit),
    .perm_i      (sel_perm),
    .res_o       (res)
  );

  assign rsp_hit_o        = (res == RES_HIT);
  assign rsp_page_fault_o = (res == RES_PFAULT);
  assign rsp_prot_fault_o = (res == RES_PROT);
  assign rsp_paddr_o      = rsp_hit_o ? {sel_pfn, req_off} : '0;
  assign stat_ref_o       = ref_v[stat_idx_i];
  assign stat_mod_o       = mod_v[stat_idx_i];

  // R5
  rsp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_hit_o, rsp_page_fault_o, rsp_prot_fault_o}));
  // R5
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(rsp_hit_o || rsp_page_fault_o || rsp_prot_fault_o));
  // R10
  one_use_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(use_v));
  // R3
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_page_fault_o || rsp_prot_fault_o) |-> (rsp_paddr_o == '0));
endmodule

// File: tb/page_xlate_unit_tb_top.sv
module page_xlate_unit_tb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_store = 1'b0;
  logic        rsp_hit, rsp_pf, rsp_prf;
  logic [31:0] rsp_paddr;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_idx = '0;
  logic        ld_valid = 1'b0;
  logic [19:0] ld_vpn = '0;
  logic [19:0] ld_pfn = '0;
  logic        ld_rd = 1'b0;
  logic        ld_wr = 1'b0;
  logic        clr_ref = 1'b0;
  logic [2:0]  stat_idx = '0;
  logic        stat_ref, stat_mod;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  page_xlate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_store_i(req_store),
    .rsp_hit_o(rsp_hit), .rsp_paddr_o(rsp_paddr),
    .rsp_page_fault_o(rsp_pf), .rsp_prot_fault_o(rsp_prf),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_valid_i(ld_valid),
    .ld_vpn_i(ld_vpn), .ld_pfn_i(ld_pfn), .ld_rd_ok_i(ld_rd), .ld_wr_ok_i(ld_wr),
    .clr_ref_i(clr_ref), .stat_idx_i(stat_idx),
    .stat_ref_o(stat_ref), .stat_mod_o(stat_mod)
  );

  // independent model of the entry store
  logic        m_val [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic        m_rd  [N];
  logic        m_wr  [N];
  logic        m_rf  [N];
  logic        m_md  [N];

  typedef struct {
    logic        hit, pf, prf;
    logic [31:0] pa;
    logic        rf, md;
    string       tag;
  } exp_t;

  exp_t exp_q [$];

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%s exp=%s", tag, act, exp);
    end
  endtask

  task automatic step(input logic rv, input logic [31:0] va, input logic st,
                      input logic le, input logic [2:0] li, input logic lv,
                      input logic [19:0] lvpn, input logic [19:0] lpfn,
                      input logic lr, input logic lw, input logic clr,
                      input logic [2:0] si, input string tag);
    exp_t e;
    int   hidx;
    @(posedge clk); #1;
    req_valid = rv; req_vaddr = va; req_store = st;
    ld_en = le; ld_idx = li; ld_valid = lv; ld_vpn = lvpn; ld_pfn = lpfn;
    ld_rd = lr; ld_wr = lw; clr_ref = clr; stat_idx = si;
    hidx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_val[i] && m_vpn[i] == va[31:12]) hidx = i;
    e.hit = 0; e.pf = 0; e.prf = 0; e.pa = '0; e.tag = tag;
    if (rv) begin
      if (hidx < 0) e.pf = 1;
      else if (st ? m_wr[hidx] : m_rd[hidx]) begin
        e.hit = 1; e.pa = {m_pfn[hidx], va[11:0]};
      end else e.prf = 1;
    end
    e.rf = m_rf[si]; e.md = m_md[si];
    exp_q.push_back(e);
    for (int i = 0; i < N; i++) begin
      if (le && li == 3'(i)) begin
        m_val[i] = lv; m_vpn[i] = lvpn; m_pfn[i] = lpfn;
        m_rd[i] = lr; m_wr[i] = lw; m_rf[i] = 0; m_md[i] = 0;
      end else begin
        if (e.hit && hidx == i) m_rf[i] = 1;
        else if (clr) m_rf[i] = 0;
        if (e.hit && st && hidx == i) m_md[i] = 1;
      end
    end
  endtask

  // shorthands
  task automatic acc(input logic [31:0] va, input logic st, input logic [2:0] si, input string tag);
    step(1, va, st, 0, 0, 0, 0, 0, 0, 0, 0, si, tag);
  endtask
  task automatic idle(input logic [2:0] si, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, si, tag);
  endtask
  task automatic load(input logic [2:0] li, input logic lv, input logic [19:0] vpn,
                      input logic [19:0] pfn, input logic lr, input logic lw, input string tag);
    step(0, 0, 0, 1, li, lv, vpn, pfn, lr, lw, 0, li, tag);
  endtask

  // monitor: compare at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check({rsp_hit, rsp_pf, rsp_prf} == {e.hit, e.pf, e.prf}, e.tag,
              $sformatf("hit/pf/prot=%b%b%b", rsp_hit, rsp_pf, rsp_prf),
              $sformatf("hit/pf/prot=%b%b%b", e.hit, e.pf, e.prf));
        check(rsp_paddr == e.pa, e.tag, $sformatf("pa=%h", rsp_paddr), $sformatf("pa=%h", e.pa));
        check({stat_ref, stat_mod} == {e.rf, e.md}, e.tag,
              $sformatf("ref/mod=%b%b", stat_ref, stat_mod), $sformatf("ref/mod=%b%b", e.rf, e.md));
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_rf[i] = 0; m_md[i] = 0;
    end
    repeat (2) @(negedge clk);
    // R12 reset state at the ports
    check({rsp_hit, rsp_pf, rsp_prf, stat_ref, stat_mod} == 5'b0 && rsp_paddr == 0, "R12 reset",
          $sformatf("%b%b%b%b%b", rsp_hit, rsp_pf, rsp_prf, stat_ref, stat_mod), "00000");
    @(posedge clk); #1 rst_n = 1'b1;

    acc(32'h1234_5678, 0, 0, "R12 empty store page faults");
    load(0, 1, 20'h12345, 20'hABCDE, 1, 0, "R8 load ro page");
    acc(32'h1234_5678, 0, 0, "R2 R1 read hit");
    idle(0, "R6 ref set after read");
    acc(32'h1234_5000, 1, 0, "R4 store to ro page");
    idle(0, "R6 fault leaves mod clear");
    load(1, 1, 20'h00001, 20'h00F00, 1, 1, "R8 load rw page");
    acc(32'h0000_1FFF, 1, 1, "R7 R1 store hit top offset");
    idle(1, "R7 mod set after store");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 clear strobe");
    idle(1, "R9 ref cleared mod kept");
    step(1, 32'h0000_1004, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R9 clear with access");
    idle(1, "R9 accessed entry stays referenced");
    idle(0, "R9 other entry cleared");
    load(2, 1, 20'h00001, 20'h22222, 1, 1, "R10 duplicate mapping");
    acc(32'h0000_1010, 0, 2, "R10 lowest index wins");
    idle(2, "R10 higher duplicate untouched");
    load(1, 0, 20'h00001, 20'h00F00, 1, 1, "R8 invalidate entry");
    acc(32'h0000_1010, 0, 2, "R8 R10 next duplicate serves");
    idle(1, "R8 invalid entry flags clear");
    step(1, 32'h1234_5ABC, 0, 1, 0, 1, 20'h12345, 20'h55555, 1, 1, 0, 0, "R11 load and access same cycle");
    idle(0, "R11 load wins flags");
    acc(32'h1234_5ABC, 1, 0, "R11 new contents used");
    load(3, 1, 20'h0BEEF, 20'h33333, 0, 1, "R8 load wo page");
    acc(32'h0BEE_F000, 0, 3, "R4 read wo page");
    idle(3, "R6 prot fault leaves ref clear");
    acc(32'h0BEE_F000, 1, 3, "R4 store wo page");
    step(0, 32'h0000_1010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, "R5 no request no output");
    load(7, 1, 20'hFFFFF, 20'h00007, 1, 0, "R8 load top page");
    acc(32'hFFFF_FFFF, 0, 7, "R1 top page and offset");
    acc(32'hFFFF_F000, 1, 7, "R4 store to top ro page");
    idle(7, "R6 top page referenced");
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule